// File: doc/BRIEF.md
# Observation Clock Router

This block picks one internal clock out of a bank of up to 32 sources, divides it by a programmable integer ratio, and drives the result onto a single observation pin. The pin lets a board-level instrument measure an internal clock. A final output stage can skip the selected and divided path and put a raw reference clock on the pin instead.

Software controls the block through one 32-bit control word on a simple synchronous write port. That port is clocked by the register clock. The word holds four fields: the source code, the divisor, a load strobe, and the pin path select. A new divisor is staged in the register. It reaches the divider only when software moves the load bit from 0 to 1.

The divider runs on the selected source clock. It sees the load bit through a synchronizer and restarts its count from zero when it detects the rising edge. A sticky flag reports one misconfiguration: the reference-clock path was chosen while the source code was not OFF.

Top module: `obs_clk_router`

## Requirements
- R1: After reset the control word reads 0x0000_0007 and `cfg_err` is 0. The pin then carries source 7 undivided.
- R2: The field positions are source code [4:0], divisor [15:8], load bit [16] and pin path select [24]. Every other bit reads 0, and writes to those bits have no effect.
- R3: The divider ratio is the divisor field plus one, so ratios 1 to 256 are possible. The output period is that ratio times the source period.
- R4: Writing a new divisor while the load bit stays at 0 leaves the output unchanged. A later write that moves the load bit from 0 to 1 applies the new divisor.
- R5: A write that changes the divisor but keeps the load bit at 1 does not reload the divider.
- R6: For an even ratio N the output is high for N/2 source cycles and low for N/2. For an odd ratio it is high for (N-1)/2 cycles and low for (N+1)/2.
- R7: A ratio of 1 passes the selected source to the pin unchanged, with the same period and the same high time.
- R8: Source codes 0x00–0x0D, 0x10, 0x11 and 0x13 route the matching `src_clk` bit into the divider. Changing the code changes the clock being divided.
- R9: Source code 0x1F (OFF) and every other code not listed in R8 hold the divider input low, so the pin shows no edges.
- R10: With bit 24 set, the pin carries `ref_clk`, whatever the source code is.
- R11: `cfg_err` rises when bit 24 is set while the source code is not 0x1F. It stays high until reset. Bit 24 set together with the OFF code leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes `wr_data` into the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word; reserved bits read 0 |
| src_clk | input | 32 | Source clock bank, one bit per source code |
| ref_clk | input | 1 | Reference clock for the bypass path |
| obs_out | output | 1 | Observation pin clock |
| cfg_err | output | 1 | Sticky flag for bypass selected with the source code not OFF |

## Verification
Each fault in the divider shows up at the pin within one output period after the load edge has passed the synchronizer. A wrong count limit changes the measured period. A wrong phase threshold changes the high time. A missed or spurious load edge leaves the previous ratio in place or brings in an unrequested one. A decode fault in the source mux shows up as edges on a pin that should be silent, or as the wrong source period. Register faults show on `rd_data` one cycle after the write. The sticky flag shows one cycle after the register takes the misconfiguration.

// File: rtl/obs_pkg.sv
package obs_pkg;
  localparam int CW_W    = 32;
  localparam int SEL_LSB = 0;
  localparam int SEL_W   = 5;
  localparam int DIV_LSB = 8;
  localparam int DIV_W   = 8;
  localparam int LD_BIT  = 16;
  localparam int BYP_BIT = 24;

  localparam logic [SEL_W-1:0] SEL_OFF   = '1;
  localparam logic [SEL_W-1:0] SEL_RESET = 5'd7;

  function automatic logic [CW_W-1:0] field_mask();
    logic [CW_W-1:0] m;
    m = '0;
    for (int i = 0; i < SEL_W; i++) m[SEL_LSB+i] = 1'b1;
    for (int i = 0; i < DIV_W; i++) m[DIV_LSB+i] = 1'b1;
    m[LD_BIT]  = 1'b1;
    m[BYP_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [CW_W-1:0] CW_MASK  = field_mask();
  localparam logic [CW_W-1:0] CW_RESET = {{(CW_W-SEL_W){1'b0}}, SEL_RESET};
endpackage

// File: rtl/obs_ctrl_reg.sv
module obs_ctrl_reg
  import obs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CW_W-1:0] wr_data,
  output logic [CW_W-1:0] ctrl,
  output logic            err
);
  logic [CW_W-1:0] ctrl_d, ctrl_q;
  logic            err_d, err_q;
  logic            misconf;

  assign misconf = ctrl_q[BYP_BIT] && (ctrl_q[SEL_LSB +: SEL_W] != SEL_OFF);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data & CW_MASK;
    err_d = err_q | misconf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CW_RESET;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl = ctrl_q;
  assign err  = err_q;

  // R2
  wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl == ($past(wr_data) & CW_MASK));
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R11
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[BYP_BIT] && ctrl[SEL_LSB +: SEL_W] != SEL_OFF) |=> err);
endmodule

// File: rtl/obs_src_mux.sv
module obs_src_mux #(
  parameter int                NUM_SRC    = 32,
  parameter logic [NUM_SRC-1:0] VALID_MASK = 32'h000B_3FFF,
  localparam int               SW         = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SW-1:0]      sel,
  output logic               clk_out
);
  logic [NUM_SRC-1:0] gated;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    if (VALID_MASK[g]) begin : g_on
      assign gated[g] = src_clk[g];
    end else begin : g_off
      assign gated[g] = 1'b0;
    end
  end

  assign clk_out = gated[sel];
endmodule

// File: rtl/obs_clk_div.sv
module obs_clk_div #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             div_clk,
  input  logic             rst_n,
  input  logic             ld_lvl,
  input  logic [DIV_W-1:0] div_in,
  output logic             div_q,
  output logic             pass_thru
);
  logic [1:0]           rs_q;
  logic                 rs_n;
  logic [SYNC_STAGES:0] ld_s_q, ld_s_d;
  logic                 ld_edge;
  logic [DIV_W-1:0]     act_q, act_d, cnt_q, cnt_d, div_eff;
  logic [DIV_W:0]       half;
  logic                 q_q, q_d;

  always_ff @(posedge div_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  assign ld_edge = ld_s_q[SYNC_STAGES-1] & ~ld_s_q[SYNC_STAGES];

  always_comb begin
    ld_s_d  = {ld_s_q[SYNC_STAGES-1:0], ld_lvl};
    div_eff = ld_edge ? div_in : act_q;
    act_d   = div_eff;
    if (ld_edge || cnt_q == act_q) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
    half    = ({1'b0, div_eff} + 1'b1) >> 1;
    q_d     = ({1'b0, cnt_d} < half);
  end

  always_ff @(posedge div_clk or negedge rs_n) begin
    if (!rs_n) begin
      ld_s_q <= '0;
      act_q  <= '0;
      cnt_q  <= '0;
      q_q    <= 1'b0;
    end else begin
      ld_s_q <= ld_s_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      q_q    <= q_d;
    end
  end

  assign div_q     = q_q;
  assign pass_thru = (act_q == '0);

  // R3
  cnt_range_chk: assert property (@(posedge div_clk) disable iff (!rs_n)
    cnt_q <= act_q);
  // R4
  load_apply_chk: assert property (@(posedge div_clk) disable iff (!rs_n)
    ld_edge |=> (cnt_q == '0) && (act_q == $past(div_in)));
endmodule

// File: rtl/obs_clk_router.sv
module obs_clk_router
  import obs_pkg::*;
#(
  parameter int                NUM_SRC     = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NUM_SRC-1:0] VALID_MASK  = 32'h000B_3FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CW_W-1:0]    wr_data,
  output logic [CW_W-1:0]    rd_data,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               ref_clk,
  output logic               obs_out,
  output logic               cfg_err
);
  localparam int SW = $clog2(NUM_SRC);

  logic [CW_W-1:0] ctrl;
  logic            div_clk, div_q, pass_thru, div_path;

  obs_ctrl_reg i_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .err     (cfg_err)
  );

  obs_src_mux #(.NUM_SRC(NUM_SRC), .VALID_MASK(VALID_MASK)) i_mux (
    .src_clk (src_clk),
    .sel     (ctrl[SEL_LSB +: SW]),
    .clk_out (div_clk)
  );

  obs_clk_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) i_div (
    .div_clk   (div_clk),
    .rst_n     (rst_n),
    .ld_lvl    (ctrl[LD_BIT]),
    .div_in    (ctrl[DIV_LSB +: DIV_W]),
    .div_q     (div_q),
    .pass_thru (pass_thru)
  );

  assign div_path = pass_thru ? div_clk : div_q;
  assign obs_out  = ctrl[BYP_BIT] ? ref_clk : div_path;
  assign rd_data  = ctrl;
endmodule

// File: tb/test_obs_clk_router.sv
`timescale 1ns/1ps
module test_obs_clk_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ref_clk = 1'b0;
  logic        obs_out, cfg_err;
  logic        s0 = 0, s1 = 0, s7 = 0, s14 = 0, s19 = 0;
  logic [31:0] src_clk;
  int          checks = 0, errors = 0, edges = 0;

  always #10  clk = ~clk;
  always #5   s0  = ~s0;
  always #7   s1  = ~s1;
  always #4   s7  = ~s7;
  always #3   s14 = ~s14;
  always #6   s19 = ~s19;
  always #15  ref_clk = ~ref_clk;

  always_comb begin
    src_clk = '0;
    src_clk[0] = s0;  src_clk[1] = s1;  src_clk[7] = s7;
    src_clk[14] = s14; src_clk[19] = s19;
  end

  always @(posedge obs_out) edges++;

  obs_clk_router i_obs_clk_router (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_clk(src_clk), .ref_clk(ref_clk),
    .obs_out(obs_out), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] cw(input logic [4:0] sel, input logic [7:0] dv,
                                     input logic ld, input logic byp);
    return {7'd0, byp, 7'd0, ld, dv, 3'd0, sel};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic meas(input string req, input real per_exp, input real hi_exp);
    realtime t0, t1, t2;
    repeat (4) @(posedge obs_out);
    t0 = $realtime; @(negedge obs_out); t1 = $realtime; @(posedge obs_out); t2 = $realtime;
    chk(req, "period ps", longint'((t2 - t0) * 1000.0), longint'(per_exp * 1000.0));
    chk(req, "high ps",   longint'((t1 - t0) * 1000.0), longint'(hi_exp * 1000.0));
  endtask

  task automatic silent(input string req);
    int e0;
    #200; e0 = edges; #1000;
    chk(req, "edges in window", edges - e0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "rd_data", rd_data, 32'h7);
    chk("R1", "cfg_err", cfg_err, 0);
    meas("R1 R7", 8.0, 4.0);
  endtask

  task automatic t_reserved;
    wr(32'hFFFF_FFFF);
    chk("R2", "rd_data", rd_data, 32'h0101_FF1F);
    chk("R11", "cfg_err with OFF", cfg_err, 0);
    meas("R10", 30.0, 15.0);
  endtask

  task automatic t_stage;
    wr(cw(5'd0, 8'd3, 1'b0, 1'b0));
    meas("R4 R7 staged", 10.0, 5.0);
    wr(cw(5'd0, 8'd3, 1'b1, 1'b0));
    meas("R3 R4 R6 even", 40.0, 20.0);
  endtask

  task automatic t_odd_noreload;
    wr(cw(5'd0, 8'd4, 1'b0, 1'b0));
    wr(cw(5'd0, 8'd4, 1'b1, 1'b0));
    meas("R6 odd", 50.0, 20.0);
    wr(cw(5'd0, 8'd1, 1'b1, 1'b0));
    #300;
    meas("R5", 50.0, 20.0);
  endtask

  task automatic t_max;
    wr(cw(5'd7, 8'd255, 1'b0, 1'b0));
    wr(cw(5'd7, 8'd255, 1'b1, 1'b0));
    meas("R3 max", 2048.0, 1024.0);
  endtask

  task automatic t_switch;
    wr(cw(5'h13, 8'd2, 1'b0, 1'b0));
    wr(cw(5'h13, 8'd2, 1'b1, 1'b0));
    meas("R8 R6", 36.0, 12.0);
    wr(cw(5'd1, 8'd2, 1'b1, 1'b0));
    meas("R8 switch", 42.0, 14.0);
  endtask

  task automatic t_off;
    wr(cw(5'h1F, 8'd2, 1'b1, 1'b0));
    silent("R9 OFF");
    wr(cw(5'h0E, 8'd2, 1'b1, 1'b0));
    silent("R9 reserved");
  endtask

  task automatic t_err;
    wr(cw(5'd0, 8'd2, 1'b1, 1'b1));
    chk("R11", "cfg_err set", cfg_err, 1);
    meas("R10 misconf", 30.0, 15.0);
    wr(cw(5'h1F, 8'd0, 1'b0, 1'b1));
    chk("R11", "cfg_err sticky", cfg_err, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reserved();
    t_stage();
    t_odd_noreload();
    t_max();
    t_switch();
    t_off();
    t_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule